// File: doc/BRIEF.md
# Debug Event Router

This block sits between a core's debug event sources and its two possible reactions. When an enabled debug event fires, the block records it in a status register and then either signals a debug interrupt to software or asks the core to halt so that an external debugger can take over. Two things make the choice. One is a single external-mode bit in the control register. The other is a per-event ownership mask that can hand chosen events back to software while the debugger owns the rest.

The block holds the control, status and ownership registers. A software port and a debugger port both write them, and the block applies the write permissions. While external mode is active, software may touch only the fields it owns. Some debugger writes need the CPU clock, so they take effect only while that clock runs. A global emulation-enable input overrides everything: when it is low, the external-mode bit has no effect and no event, watchpoint or halt can happen. A halt can also be requested from a bit in the debugger control register or from an active-low external pin. Each halt request is held until the core acknowledges it, and the debug-mode state then lasts until a resume.

Top module: `dbg_event_router`

## Requirements
- R1: The effective external mode is the external-mode bit (control bit N_EV) AND the emulation-enable input. While it is 0, every enabled event that fires sets its status bit, and `irq_o` is high whenever any status bit is set. No event raises `halt_req_o` in this mode.
- R2: While effective external mode is 1, an enabled event fires as follows. If the event is not owned by software (its ownership bit is 0), it sets its status bit and requests a halt, and its status bit does not drive `irq_o`. If its ownership bit is 1, its status bit drives `irq_o`.
- R3: While effective external mode is 1, a software write to the control register (select 0) changes only the enable bits whose ownership bit is 1. A software status clear (select 1) clears only owned bits. Software can never write the external-mode bit.
- R4: A debugger control write that changes the external-mode bit from 0 to 1 leaves the enable bits [N_EV-1:0] unchanged, whatever the data written there.
- R5: While `emu_en_i` is 0, no event fires, so status is not set and `wp_o` is 0. `halt_req_o` is 0 from the next cycle on, and no new halt is requested. Software writes behave as when external mode is 0.
- R6: A halt is requested by any one of three sources: a non-owned event (R2), a debugger write of 1 to bit 0 of the debugger control register (select 3), or `ext_halt_n_i` sampled low. `halt_req_o` rises one cycle after the request and stays high until `halt_ack_i` is sampled. `in_debug_o` then goes high and stays high until `resume_i` is sampled. No new request is taken while `in_debug_o` is high.
- R7: Debugger writes to the enable bits, the status register (select 1) and the ownership register (select 2) take effect only while `cpu_clk_on_i` is 1. Writes to the external-mode bit and to the debugger control register take effect at any time.
- R8: Bit 1 of the debugger control register is stored and drives `clk_req_o`.
- R9: Status bits are cleared by writing 1, from either port. An event firing in the same cycle as a clear of the same bit leaves that bit set.
- R10: In a cycle where the debugger port writes, any software write is dropped. Only the debugger port can write the ownership register.
- R11: `wp_o` equals the vector of events that fire this cycle (`event_i` AND enable AND `emu_en_i`). It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_en_i | input | 1 | Global emulation enable |
| cpu_clk_on_i | input | 1 | CPU clock running |
| sw_wr_i | input | 1 | Software write strobe |
| sw_sel_i | input | 2 | Software register select (0 control, 1 status) |
| sw_wdata_i | input | N_EV | Software write data |
| dbg_wr_i | input | 1 | Debugger write strobe |
| dbg_sel_i | input | 2 | Debugger select (0 control, 1 status, 2 ownership, 3 debugger control) |
| dbg_wdata_i | input | N_EV+1 | Debugger write data |
| event_i | input | N_EV | Raw debug event pulses |
| ext_halt_n_i | input | 1 | Active-low external halt request |
| halt_ack_i | input | 1 | Core acknowledges halt |
| resume_i | input | 1 | Core leaves debug mode |
| ctrl_o | output | N_EV+1 | Control register: enables, external-mode bit on top |
| status_o | output | N_EV | Event status |
| owner_o | output | N_EV | Software ownership mask |
| clk_req_o | output | 1 | Request to start the CPU clock |
| irq_o | output | 1 | Debug interrupt |
| halt_req_o | output | 1 | Halt request to the core |
| in_debug_o | output | 1 | Core is in debug mode |
| wp_o | output | N_EV | Watchpoint outputs |

## Verification
The bench aims at these corner cases:
- Entering external mode with junk in the enable field. A design that wrote the whole register would silently disable events.
- Software writes under a partial ownership mask. A design that ignored the mask, or ignored the write entirely, would let software change bits it does not own, or would freeze bits it does own.
- Debugger status and ownership writes while the CPU clock is stopped. A design that accepted them would corrupt state the debugger assumes is still in place.
- Dropping emulation enable while a halt is pending or the external pin is held low. A design that kept the request would halt a core that has debugging switched off.
- Same-cycle collisions between the two ports, and between an event and a clear. Getting either wrong loses an event or applies the wrong port's data.

// File: rtl/dbg_route_pkg.sv
package dbg_route_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_OWN  = 2'd2,
      SEL_DCTL = 2'd3
   } reg_sel_e;

   localparam int DCTL_HALT_BIT = 0;
   localparam int DCTL_CLK_BIT  = 1;
endpackage

// File: rtl/dbg_regs.sv
module dbg_regs
   import dbg_route_pkg::*;
#(
   parameter int N_EV = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            emu_en_i,
   input  logic            cpu_clk_on_i,
   input  logic            sw_wr_i,
   input  logic [1:0]      sw_sel_i,
   input  logic [N_EV-1:0] sw_wdata_i,
   input  logic            dbg_wr_i,
   input  logic [1:0]      dbg_sel_i,
   input  logic [N_EV:0]   dbg_wdata_i,
   input  logic [N_EV-1:0] fire_i,
   output logic [N_EV-1:0] en_o,
   output logic            xdm_o,
   output logic [N_EV-1:0] status_o,
   output logic [N_EV-1:0] owner_o,
   output logic            clk_req_o,
   output logic [N_EV-1:0] sw_mask_o,
   output logic            halt_cmd_o
);
   localparam int XDM_BIT = N_EV;

   logic [N_EV-1:0] en_q, own_q, st_q, clr_vec;
   logic            xdm_q, ck_q, eff_xdm;
   logic            dbg_ctrl, dbg_stat, dbg_own, dbg_dctl;
   logic            sw_ctrl, sw_stat, entering;

   assign eff_xdm   = xdm_q & emu_en_i;
   assign sw_mask_o = eff_xdm ? own_q : {N_EV{1'b1}};

   assign dbg_ctrl = dbg_wr_i && (dbg_sel_i == SEL_CTRL);
   assign dbg_stat = dbg_wr_i && (dbg_sel_i == SEL_STAT);
   assign dbg_own  = dbg_wr_i && (dbg_sel_i == SEL_OWN);
   assign dbg_dctl = dbg_wr_i && (dbg_sel_i == SEL_DCTL);
   assign sw_ctrl  = sw_wr_i && !dbg_wr_i && (sw_sel_i == SEL_CTRL);
   assign sw_stat  = sw_wr_i && !dbg_wr_i && (sw_sel_i == SEL_STAT);
   assign entering = dbg_ctrl && !xdm_q && dbg_wdata_i[XDM_BIT];

   // control register: enables plus external-mode bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         xdm_q <= 1'b0;
      end else if (dbg_ctrl) begin
         xdm_q <= dbg_wdata_i[XDM_BIT];
         if (!entering && cpu_clk_on_i)
            en_q <= dbg_wdata_i[N_EV-1:0];
      end else if (sw_ctrl) begin
         en_q <= (en_q & ~sw_mask_o) | (sw_wdata_i & sw_mask_o);
      end
   end

   always_comb begin
      clr_vec = '0;
      if (dbg_stat && cpu_clk_on_i)
         clr_vec = dbg_wdata_i[N_EV-1:0];
      else if (sw_stat)
         clr_vec = sw_wdata_i & sw_mask_o;
   end

   // status bits, set wins over clear
   for (genvar i = 0; i < N_EV; i++) begin : g_stat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st_q[i] <= 1'b0;
         else
            st_q[i] <= fire_i[i] | (st_q[i] & ~clr_vec[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= '0;
         ck_q  <= 1'b0;
      end else begin
         if (dbg_own && cpu_clk_on_i)
            own_q <= dbg_wdata_i[N_EV-1:0];
         if (dbg_dctl)
            ck_q <= dbg_wdata_i[DCTL_CLK_BIT];
      end
   end

   assign halt_cmd_o = dbg_dctl && dbg_wdata_i[DCTL_HALT_BIT];
   assign en_o       = en_q;
   assign xdm_o      = xdm_q;
   assign status_o   = st_q;
   assign owner_o    = own_q;
   assign clk_req_o  = ck_q;

   p_own_dbg_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(dbg_wr_i && dbg_sel_i == SEL_OWN) |=> $stable(own_q));
   p_xdm_sw_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(dbg_wr_i && dbg_sel_i == SEL_CTRL) |=> $stable(xdm_q));
   p_entry_keeps_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_wr_i && dbg_sel_i == SEL_CTRL && !xdm_q && dbg_wdata_i[XDM_BIT])
      |=> (xdm_q && $stable(en_q)));
endmodule

// File: rtl/dbg_event_path.sv
module dbg_event_path #(
   parameter int N_EV    = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            emu_en_i,
   input  logic [N_EV-1:0] event_i,
   input  logic [N_EV-1:0] en_i,
   input  logic [N_EV-1:0] sw_mask_i,
   input  logic [N_EV-1:0] status_i,
   output logic [N_EV-1:0] fire_o,
   output logic            halt_ev_o,
   output logic            irq_o
);
   logic irq_now;

   assign fire_o    = event_i & en_i & {N_EV{emu_en_i}};
   assign halt_ev_o = |(fire_o & ~sw_mask_i);
   assign irq_now   = |(status_i & sw_mask_i);

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_now;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_now;
   end

   p_status_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|fire_o) |=> ((status_i & $past(fire_o)) == $past(fire_o)));
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic emu_en_i,
   input  logic halt_ev_i,
   input  logic halt_cmd_i,
   input  logic ext_halt_n_i,
   input  logic halt_ack_i,
   input  logic resume_i,
   output logic halt_req_o,
   output logic in_debug_o
);
   logic pend_q, dbg_q, want;

   assign want = halt_ev_i | halt_cmd_i | ~ext_halt_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         dbg_q  <= 1'b0;
      end else if (dbg_q) begin
         pend_q <= 1'b0;
         if (resume_i) dbg_q <= 1'b0;
      end else if (!emu_en_i) begin
         pend_q <= 1'b0;
      end else if (pend_q) begin
         if (halt_ack_i) begin
            pend_q <= 1'b0;
            dbg_q  <= 1'b1;
         end
      end else if (want) begin
         pend_q <= 1'b1;
      end
   end

   assign halt_req_o = pend_q;
   assign in_debug_o = dbg_q;

   p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req_o && !halt_ack_i && emu_en_i) |=> halt_req_o);
   p_ack_enters_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req_o && halt_ack_i && emu_en_i) |=> (in_debug_o && !halt_req_o));
   p_no_halt_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !emu_en_i |=> !halt_req_o);
endmodule

// File: rtl/dbg_event_router.sv
module dbg_event_router
   import dbg_route_pkg::*;
#(
   parameter int N_EV    = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            emu_en_i,
   input  logic            cpu_clk_on_i,
   input  logic            sw_wr_i,
   input  logic [1:0]      sw_sel_i,
   input  logic [N_EV-1:0] sw_wdata_i,
   input  logic            dbg_wr_i,
   input  logic [1:0]      dbg_sel_i,
   input  logic [N_EV:0]   dbg_wdata_i,
   input  logic [N_EV-1:0] event_i,
   input  logic            ext_halt_n_i,
   input  logic            halt_ack_i,
   input  logic            resume_i,
   output logic [N_EV:0]   ctrl_o,
   output logic [N_EV-1:0] status_o,
   output logic [N_EV-1:0] owner_o,
   output logic            clk_req_o,
   output logic            irq_o,
   output logic            halt_req_o,
   output logic            in_debug_o,
   output logic [N_EV-1:0] wp_o
);
   if (N_EV < 2 || N_EV > 30) begin : g_bad_nev
      $error("dbg_event_router: N_EV must lie in 2..30");
   end

   logic [N_EV-1:0] en, sw_mask, fire;
   logic            xdm, halt_ev, halt_cmd;

   dbg_regs #(.N_EV(N_EV)) regs_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .emu_en_i     (emu_en_i),
      .cpu_clk_on_i (cpu_clk_on_i),
      .sw_wr_i      (sw_wr_i),
      .sw_sel_i     (sw_sel_i),
      .sw_wdata_i   (sw_wdata_i),
      .dbg_wr_i     (dbg_wr_i),
      .dbg_sel_i    (dbg_sel_i),
      .dbg_wdata_i  (dbg_wdata_i),
      .fire_i       (fire),
      .en_o         (en),
      .xdm_o        (xdm),
      .status_o     (status_o),
      .owner_o      (owner_o),
      .clk_req_o    (clk_req_o),
      .sw_mask_o    (sw_mask),
      .halt_cmd_o   (halt_cmd)
   );

   dbg_event_path #(.N_EV(N_EV), .IRQ_REG(IRQ_REG)) path_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .emu_en_i  (emu_en_i),
      .event_i   (event_i),
      .en_i      (en),
      .sw_mask_i (sw_mask),
      .status_i  (status_o),
      .fire_o    (fire),
      .halt_ev_o (halt_ev),
      .irq_o     (irq_o)
   );

   dbg_halt_ctl halt_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .emu_en_i     (emu_en_i),
      .halt_ev_i    (halt_ev),
      .halt_cmd_i   (halt_cmd),
      .ext_halt_n_i (ext_halt_n_i),
      .halt_ack_i   (halt_ack_i),
      .resume_i     (resume_i),
      .halt_req_o   (halt_req_o),
      .in_debug_o   (in_debug_o)
   );

   assign ctrl_o = {xdm, en};
   assign wp_o   = fire;
endmodule

// File: tb/dbg_event_router_tb_top.sv
`timescale 1ns/1ps
module dbg_event_router_tb_top;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic emu_en = 1'b1, clk_on = 1'b1;
   logic sw_wr = 1'b0;
   logic [1:0] sw_sel = 2'd0;
   logic [N-1:0] sw_wd = '0;
   logic dbg_wr = 1'b0;
   logic [1:0] dbg_sel = 2'd0;
   logic [N:0] dbg_wd = '0;
   logic [N-1:0] ev = '0;
   logic ext_n = 1'b1, ack = 1'b0, resume = 1'b0;

   logic [N:0] ctrl_o;
   logic [N-1:0] status_o, owner_o, wp_o;
   logic clk_req_o, irq_o, halt_req_o, in_debug_o;

   int nchk = 0, nfail = 0;
   bit done = 0;

   // reference model state
   logic [N-1:0] m_en, m_st, m_own;
   logic m_x, m_ck, m_pend, m_dbg;

   always #2.5 clk = ~clk;

   dbg_event_router #(.N_EV(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .emu_en_i(emu_en), .cpu_clk_on_i(clk_on),
      .sw_wr_i(sw_wr), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wd),
      .dbg_wr_i(dbg_wr), .dbg_sel_i(dbg_sel), .dbg_wdata_i(dbg_wd),
      .event_i(ev), .ext_halt_n_i(ext_n), .halt_ack_i(ack), .resume_i(resume),
      .ctrl_o(ctrl_o), .status_o(status_o), .owner_o(owner_o),
      .clk_req_o(clk_req_o), .irq_o(irq_o), .halt_req_o(halt_req_o),
      .in_debug_o(in_debug_o), .wp_o(wp_o)
   );

   function automatic logic [N-1:0] swmask();
      return (m_x && emu_en) ? m_own : {N{1'b1}};
   endfunction

   function automatic logic [N-1:0] fired();
      return emu_en ? (ev & m_en) : '0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_st = '0; m_own = '0; m_x = 0; m_ck = 0; m_pend = 0; m_dbg = 0;
      end else begin : upd
         logic [N-1:0] mk, f, clr, n_en, n_own;
         logic n_x, n_ck, n_pend, n_dbg, cmd, req;
         mk = swmask(); f = fired(); clr = '0;
         n_en = m_en; n_own = m_own; n_x = m_x; n_ck = m_ck; cmd = 0;
         if (dbg_wr) begin
            case (dbg_sel)
               2'd0: begin
                  n_x = dbg_wd[N];
                  if (clk_on && !(m_x == 0 && dbg_wd[N] == 1)) n_en = dbg_wd[N-1:0];
               end
               2'd1: if (clk_on) clr = dbg_wd[N-1:0];
               2'd2: if (clk_on) n_own = dbg_wd[N-1:0];
               default: begin n_ck = dbg_wd[1]; cmd = dbg_wd[0]; end
            endcase
         end else if (sw_wr && sw_sel == 2'd0) begin
            for (int i = 0; i < N; i++) if (mk[i]) n_en[i] = sw_wd[i];
         end else if (sw_wr && sw_sel == 2'd1) begin
            clr = sw_wd & mk;
         end
         req = (|(f & ~mk)) || cmd || !ext_n;
         n_pend = m_pend; n_dbg = m_dbg;
         if (m_dbg) begin n_pend = 0; if (resume) n_dbg = 0; end
         else if (!emu_en) n_pend = 0;
         else if (m_pend) begin if (ack) begin n_pend = 0; n_dbg = 1; end end
         else if (req) n_pend = 1;
         m_st = (m_st & ~clr) | f;
         m_en = n_en; m_own = n_own; m_x = n_x; m_ck = n_ck; m_pend = n_pend; m_dbg = n_dbg;
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R4 ctrl", 64'(ctrl_o), 64'({m_x, m_en}));
      chk("R9 status", 64'(status_o), 64'(m_st));
      chk("R10 owner", 64'(owner_o), 64'(m_own));
      chk("R8 clkreq", 64'(clk_req_o), 64'(m_ck));
      chk("R1 irq", 64'(irq_o), 64'(|(m_st & swmask())));
      chk("R6 halt", 64'(halt_req_o), 64'(m_pend));
      chk("R6 indebug", 64'(in_debug_o), 64'(m_dbg));
      chk("R11 wp", 64'(wp_o), 64'(fired()));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      sw_wr = 0; dbg_wr = 0; ev = '0; ack = 0; resume = 0;
   endtask

   task automatic dwr(logic [1:0] s, logic [N:0] d);
      dbg_wr = 1; dbg_sel = s; dbg_wd = d; tick(); idle();
   endtask

   task automatic swr(logic [1:0] s, logic [N-1:0] d);
      sw_wr = 1; sw_sel = s; sw_wd = d; tick(); idle();
   endtask

   initial begin : wd
      #(200000 * 5);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin : stim
      logic [N-1:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset ctrl", 64'(ctrl_o), 0);
      chk("R6 reset halt", 64'(halt_req_o), 0);

      swr(2'd0, 8'hFF);
      ev = 8'h01; tick(); idle();
      chk("R1 irq raised", 64'(irq_o), 1);
      chk("R1 no halt", 64'(halt_req_o), 0);
      swr(2'd1, 8'h01);
      chk("R9 w1c", 64'(status_o), 0);

      dwr(2'd0, 9'h100);
      chk("R4 enables kept", 64'(ctrl_o), 64'h1FF);
      dwr(2'd2, 9'h00F);
      ev = 8'h10; tick(); idle();
      chk("R2 halt from unowned", 64'(halt_req_o), 1);
      chk("R2 no irq unowned", 64'(irq_o), 0);
      ev = 8'h01; tick(); idle();
      chk("R2 irq from owned", 64'(irq_o), 1);
      swr(2'd0, 8'h00);
      chk("R3 owned only", 64'(ctrl_o), 64'h1F0);

      ack = 1; tick(); idle();
      chk("R6 entered", 64'(in_debug_o), 1);
      chk("R6 req dropped", 64'(halt_req_o), 0);
      resume = 1; tick(); idle();

      clk_on = 0;
      dwr(2'd2, 9'h000);
      chk("R7 own blocked", 64'(owner_o), 64'h0F);
      dwr(2'd3, 9'h002);
      chk("R7 dctl allowed", 64'(clk_req_o), 1);
      clk_on = 1;

      sw_wr = 1; sw_sel = 2'd0; sw_wd = 8'h00;
      dbg_wr = 1; dbg_sel = 2'd2; dbg_wd = 9'h0FF;
      tick(); idle();
      chk("R10 sw dropped", 64'(ctrl_o), 64'h1F0);

      emu_en = 0;
      snap = status_o;
      ev = 8'hFF; #1;
      chk("R5 wp off", 64'(wp_o), 0);
      tick(); idle();
      chk("R5 status kept", 64'(status_o), 64'(snap));
      ext_n = 0; tick(); tick();
      chk("R5 no halt", 64'(halt_req_o), 0);
      ext_n = 1;
      swr(2'd0, 8'h00);
      chk("R5 sw write open", 64'(ctrl_o), 64'h100);

      emu_en = 1; ext_n = 0; tick(); ext_n = 1;
      chk("R6 pin halt", 64'(halt_req_o), 1);
      ack = 1; tick(); idle(); resume = 1; tick(); idle();
      dwr(2'd3, 9'h003); tick();
      chk("R6 dctl halt", 64'(halt_req_o), 1);
      ack = 1; tick(); idle(); resume = 1; tick(); idle();

      for (int k = 0; k < 3000; k++) begin
         emu_en = ($urandom % 10) != 0;
         clk_on = ($urandom % 5) != 0;
         sw_wr = ($urandom % 5) == 0;
         sw_sel = 2'($urandom);
         sw_wd = N'($urandom);
         dbg_wr = ($urandom % 7) == 0;
         dbg_sel = 2'($urandom);
         dbg_wd = (N+1)'($urandom);
         ev = (($urandom % 3) == 0) ? N'($urandom) : '0;
         ext_n = ($urandom % 20) != 0;
         ack = ($urandom % 3) == 0;
         resume = ($urandom % 8) == 0;
         tick();
      end
      idle();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule